// File: doc/BRIEF.md
# ECC Partial-Write Read-Modify-Write Unit

This unit sits between a write-request source and a memory whose doublewords are protected by check bits. It makes sure that memory only ever sees complete 64-bit writes while check-bit protection is active. A request carries a doubleword address, 64 bits of data and 8 byte-lane enables. When all 8 lanes are enabled, the word goes straight out with freshly computed check bits.

When fewer lanes are enabled, the unit first reads the stored doubleword. It then replaces only the enabled lanes with the new bytes, recomputes the check bits over the merged word and writes the whole doubleword back. The request side is stalled for the whole sequence, so no other write can slip in between the read and the write-back. The check bits are a simple stand-in: one even-parity bit per data byte.

A configuration input turns the check-bit write protection off. While it is set, partial writes skip the read and merge steps and go out with their own byte enables, which leaves the stored check bits stale. Merged (coalesced) partial writes depend on the read-modify-write path. For that reason, any write accepted while coalescing is enabled and protection is turned off raises an invalid-configuration pulse.

Top module: `ecc_rmw_unit`

## Requirements
- R1: After reset has been released and synchronised, `req_ready` is 1 and `mem_rd_req`, `mem_wr_req` and `cfg_invalid` are 0.
- R2: A request accepted with `req_be` = 8'hFF produces no memory read. It produces exactly one `mem_wr_req` cycle in the cycle after acceptance, carrying the request address, the request data and `mem_wr_be` = 8'hFF.
- R3: A request accepted with `req_be` != 8'hFF while `cfg_wdis` = 0 produces a single-cycle `mem_rd_req` carrying the request address in the cycle after acceptance, and no write before the read data returns.
- R4: For such a request, `mem_wr_req` is asserted once, two cycles after the edge that samples `mem_rd_ack`. Byte lane i (bits 8i+7:8i) of `mem_wr_data` equals the request byte when `req_be[i]` = 1 and the read byte otherwise, and `mem_wr_be` = 8'hFF.
- R5: On every write, `mem_wr_chk[i]` is the XOR of the 8 bits of `mem_wr_data` lane i, so that each byte plus its check bit holds an even number of ones.
- R6: `req_ready` is 0 from the cycle after acceptance through the write cycle, and is 1 again in the cycle after the write.
- R7: A partial request accepted with `cfg_wdis` = 1 issues no read. It writes in the cycle after acceptance with the request data, the request byte enables as `mem_wr_be`, and check bits computed over the request data.
- R8: `cfg_invalid` is a one-cycle pulse in the cycle after a write is accepted with `cfg_coalesce` = 1 and `cfg_wdis` = 1, and is 0 in every other cycle.
- R9: The configuration inputs are sampled at acceptance. Changing `cfg_wdis` during a read-modify-write sequence does not change its outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wdis | input | 1 | 1 = check-bit write protection off, partial writes bypass the merge |
| cfg_coalesce | input | 1 | 1 = write merging is enabled upstream |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | ADDR_W | Doubleword address |
| req_data | input | 64 | Write data |
| req_be | input | 8 | Byte-lane enables, bit i covers data bits 8i+7:8i |
| mem_rd_req | output | 1 | Single-cycle read request to memory |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Read data |
| mem_wr_req | output | 1 | Single-cycle write to memory |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | 64 | Write data |
| mem_wr_be | output | 8 | Write byte enables |
| mem_wr_chk | output | 8 | Check bits, one even-parity bit per byte |
| cfg_invalid | output | 1 | Pulse: write accepted with coalescing on and protection off |

## Verification
A full-lane or bypassed write, the invalid-configuration pulse and the drop of `req_ready` are all due in the cycle right after the accepting edge. The read request also appears in that cycle. The merged write appears two cycles after the edge that samples `mem_rd_ack`, and `req_ready` returns one cycle after the write. The bench drives inputs at the falling edge and steps one falling edge at a time from acceptance, checking each output in exactly the cycle listed above. While the bench's memory model holds back the read data for a random 0 to 3 cycles, it confirms that nothing is written early.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_READ_REQ  = 3'd1,
    ST_READ_WAIT = 3'd2,
    ST_MERGE     = 3'd3,
    ST_WRITE     = 3'd4
  } rmw_state_e;
endpackage

// File: rtl/ecc_rmw_rst_sync.sv
module ecc_rmw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ecc_byte_parity.sv
module ecc_byte_parity #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  chk
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign chk[g] = ^data[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ecc_lane_merge.sv
module ecc_lane_merge #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [DATA_W-1:0] new_data,
  input  logic [DATA_W-1:0] old_data,
  input  logic [LANES-1:0]  lane_en,
  output logic [DATA_W-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = lane_en[g] ? new_data[g*LANE_W +: LANE_W]
                                                   : old_data[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ecc_rmw_seq.sv
module ecc_rmw_seq
  import ecc_rmw_pkg::*;
(
  input  logic clk,
  input  logic rst_sync_n,
  input  logic accept,
  input  logic direct_write,
  input  logic rd_ack,
  output logic idle,
  output logic load_req,
  output logic load_rd,
  output logic do_merge,
  output logic rd_req,
  output logic wr_req
);
  rmw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (accept) state_d = direct_write ? ST_WRITE : ST_READ_REQ;
      ST_READ_REQ:  state_d = ST_READ_WAIT;
      ST_READ_WAIT: if (rd_ack) state_d = ST_MERGE;
      ST_MERGE:     state_d = ST_WRITE;
      ST_WRITE:     state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  assign idle     = (state_q == ST_IDLE);
  assign load_req = idle && accept;
  assign load_rd  = (state_q == ST_READ_WAIT) && rd_ack;
  assign do_merge = (state_q == ST_MERGE);
  assign rd_req   = (state_q == ST_READ_REQ);
  assign wr_req   = (state_q == ST_WRITE);
endmodule

// File: rtl/ecc_rmw_datapath.sv
module ecc_rmw_datapath #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              load_req,
  input  logic              load_rd,
  input  logic              do_merge,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  wbe,
  output logic [LANES-1:0]  wchk
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, wdata_d, rdbuf_q, merged;
  logic [LANES-1:0]  be_q, be_d, chk_q, chk_d, chk_req, chk_merged;

  ecc_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .new_data(wdata_q), .old_data(rdbuf_q), .lane_en(be_q), .merged(merged)
  );

  ecc_byte_parity #(.LANES(LANES), .LANE_W(LANE_W)) u_par_req (
    .data(req_data), .chk(chk_req)
  );

  ecc_byte_parity #(.LANES(LANES), .LANE_W(LANE_W)) u_par_mrg (
    .data(merged), .chk(chk_merged)
  );

  always_comb begin
    wdata_d = wdata_q;
    be_d    = be_q;
    chk_d   = chk_q;
    if (load_req) begin
      wdata_d = req_data;
      be_d    = req_be;
      chk_d   = chk_req;
    end else if (do_merge) begin
      wdata_d = merged;
      be_d    = '1;
      chk_d   = chk_merged;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      chk_q   <= '0;
      rdbuf_q <= '0;
    end else begin
      if (load_req) addr_q <= req_addr;
      if (load_req || do_merge) begin
        wdata_q <= wdata_d;
        be_q    <= be_d;
        chk_q   <= chk_d;
      end
      if (load_rd) rdbuf_q <= rd_data;
    end
  end

  assign addr  = addr_q;
  assign wdata = wdata_q;
  assign wbe   = be_q;
  assign wchk  = chk_q;
endmodule

// File: rtl/ecc_rmw_cfgchk.sv
module ecc_rmw_cfgchk (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic accept,
  input  logic wdis,
  input  logic coalesce,
  output logic invalid
);
  logic inv_q, inv_d;

  always_comb inv_d = accept && wdis && coalesce;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) inv_q <= 1'b0;
    else             inv_q <= inv_d;
  end

  assign invalid = inv_q;
endmodule

// File: rtl/ecc_rmw_unit.sv
module ecc_rmw_unit #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wdis,
  input  logic              cfg_coalesce,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [LANES-1:0]  req_be,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic [LANES-1:0]  mem_wr_be,
  output logic [LANES-1:0]  mem_wr_chk,
  output logic              cfg_invalid
);
  logic rst_sync_n, idle, accept, direct_write;
  logic load_req, load_rd, do_merge;
  logic [ADDR_W-1:0] addr;

  ecc_rmw_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign req_ready    = idle && rst_sync_n;
  assign accept       = req_valid && req_ready;
  assign direct_write = (&req_be) || cfg_wdis;

  ecc_rmw_seq u_seq (
    .clk(clk), .rst_sync_n(rst_sync_n), .accept(accept),
    .direct_write(direct_write), .rd_ack(mem_rd_ack), .idle(idle),
    .load_req(load_req), .load_rd(load_rd), .do_merge(do_merge),
    .rd_req(mem_rd_req), .wr_req(mem_wr_req)
  );

  ecc_rmw_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rst_sync_n(rst_sync_n), .load_req(load_req),
    .load_rd(load_rd), .do_merge(do_merge), .req_addr(req_addr),
    .req_data(req_data), .req_be(req_be), .rd_data(mem_rd_data),
    .addr(addr), .wdata(mem_wr_data), .wbe(mem_wr_be), .wchk(mem_wr_chk)
  );

  ecc_rmw_cfgchk u_cfg (
    .clk(clk), .rst_sync_n(rst_sync_n), .accept(accept),
    .wdis(cfg_wdis), .coalesce(cfg_coalesce), .invalid(cfg_invalid)
  );

  assign mem_rd_addr = addr;
  assign mem_wr_addr = addr;
endmodule

// File: rtl/ecc_rmw_checker.sv
module ecc_rmw_checker #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wdis,
  input logic              cfg_coalesce,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LANES-1:0]  req_be,
  input logic              mem_rd_req,
  input logic              mem_wr_req,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic [LANES-1:0]  mem_wr_be,
  input logic [LANES-1:0]  mem_wr_chk,
  input logic              cfg_invalid
);
  logic acc;
  logic byp_seen_q;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   byp_seen_q <= 1'b0;
    else if (acc) byp_seen_q <= cfg_wdis;
  end

  function automatic logic parity_ok(logic [DATA_W-1:0] d, logic [LANES-1:0] c);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if ((^d[i*LANE_W +: LANE_W]) != c[i]) ok = 1'b0;
    end
    return ok;
  endfunction

  a_r2_full_goes_to_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (&req_be)) |=> (mem_wr_req && !mem_rd_req));

  a_r3_partial_reads_first: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !(&req_be) && !cfg_wdis) |=> (mem_rd_req && !mem_wr_req));

  a_r3_read_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

  a_r4_full_lanes_when_protected: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !byp_seen_q) |-> (&mem_wr_be));

  a_r5_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> parity_ok(mem_wr_data, mem_wr_chk));

  a_r6_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);

  a_r6_no_ready_in_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || mem_wr_req) |-> !req_ready);

  a_r6_one_access_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_req, mem_wr_req}));

  a_r8_invalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cfg_wdis && cfg_coalesce) |=> cfg_invalid);

  a_r8_invalid_only_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_invalid |=> !cfg_invalid);
endmodule

bind ecc_rmw_unit ecc_rmw_checker #(
  .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
) u_checker (
  .clk(clk), .rst_n(rst_n), .cfg_wdis(cfg_wdis), .cfg_coalesce(cfg_coalesce),
  .req_valid(req_valid), .req_ready(req_ready), .req_be(req_be),
  .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_wr_data(mem_wr_data),
  .mem_wr_be(mem_wr_be), .mem_wr_chk(mem_wr_chk), .cfg_invalid(cfg_invalid)
);

// File: tb/ecc_rmw_unit_tb_top.sv
module ecc_rmw_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk, rst_n;
  logic        cfg_wdis, cfg_coalesce;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic [63:0] req_data;
  logic [7:0]  req_be;
  logic        mem_rd_req, mem_rd_ack;
  logic [31:0] mem_rd_addr, mem_wr_addr;
  logic [63:0] mem_rd_data, mem_wr_data;
  logic        mem_wr_req;
  logic [7:0]  mem_wr_be, mem_wr_chk;
  logic        cfg_invalid;

  int n_checks = 0;
  int n_fail = 0;
  logic finished = 1'b0;
  logic [63:0] mem_model [16];

  ecc_rmw_unit #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wdis(cfg_wdis), .cfg_coalesce(cfg_coalesce),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .req_be(req_be), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_be(mem_wr_be), .mem_wr_chk(mem_wr_chk), .cfg_invalid(cfg_invalid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_chk(logic [63:0] d);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) c[i] = ^d[i*8 +: 8];
    return c;
  endfunction

  function automatic logic [63:0] exp_merge(logic [63:0] nw, logic [63:0] old, logic [7:0] be);
    logic [63:0] m;
    for (int i = 0; i < 8; i++) m[i*8 +: 8] = be[i] ? nw[i*8 +: 8] : old[i*8 +: 8];
    return m;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG_CYCLES) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG_CYCLES);
      report();
    end
  end

  // One request, stepped one falling edge at a time from acceptance.
  task automatic do_write(logic [3:0] a, logic [63:0] d, logic [7:0] be,
                          logic wdis, logic coal, int lat, logic flip_cfg);
    logic [63:0] exp_w;
    logic [7:0]  exp_be;
    cfg_wdis     = wdis;
    cfg_coalesce = coal;
    req_addr     = {28'h0, a};
    req_data     = d;
    req_be       = be;
    req_valid    = 1'b1;
    check("R6 ready before accept", {63'b0, req_ready}, 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R6 ready low after accept", {63'b0, req_ready}, 64'd0);
    check("R8 invalid pulse", {63'b0, cfg_invalid}, {63'b0, wdis & coal});
    if ((&be) || wdis) begin
      exp_be = wdis ? be : 8'hFF;
      check("R2/R7 no read", {63'b0, mem_rd_req}, 64'd0);
      check("R2/R7 write issued", {63'b0, mem_wr_req}, 64'd1);
      check("R2/R7 write addr", {32'b0, mem_wr_addr}, {60'b0, a});
      check("R2/R7 write data", mem_wr_data, d);
      check("R2/R7 write be", {56'b0, mem_wr_be}, {56'b0, exp_be});
      check("R5 check bits", {56'b0, mem_wr_chk}, {56'b0, exp_chk(d)});
      for (int i = 0; i < 8; i++) if (be[i]) mem_model[a][i*8 +: 8] = d[i*8 +: 8];
    end else begin
      check("R3 read issued", {63'b0, mem_rd_req}, 64'd1);
      check("R3 read addr", {32'b0, mem_rd_addr}, {60'b0, a});
      check("R3 no early write", {63'b0, mem_wr_req}, 64'd0);
      if (flip_cfg) cfg_wdis = 1'b1;
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        check("R3 wait no write", {63'b0, mem_wr_req}, 64'd0);
        check("R6 ready low while waiting", {63'b0, req_ready}, 64'd0);
      end
      @(negedge clk);
      check("R3 read single cycle", {63'b0, mem_rd_req}, 64'd0);
      mem_rd_ack  = 1'b1;
      mem_rd_data = mem_model[a];
      @(negedge clk);
      mem_rd_ack  = 1'b0;
      mem_rd_data = '0;
      check("R4 no write in merge cycle", {63'b0, mem_wr_req}, 64'd0);
      @(negedge clk);
      exp_w = exp_merge(d, mem_model[a], be);
      check("R4 merged write issued", {63'b0, mem_wr_req}, 64'd1);
      check("R4 merged data", mem_wr_data, exp_w);
      check("R4 full be", {56'b0, mem_wr_be}, 64'hFF);
      check("R4 write addr", {32'b0, mem_wr_addr}, {60'b0, a});
      check("R5 merged check bits", {56'b0, mem_wr_chk}, {56'b0, exp_chk(exp_w)});
      check("R6 ready low in write", {63'b0, req_ready}, 64'd0);
      if (flip_cfg) check("R9 config sampled at accept", {63'b0, mem_wr_be == 8'hFF}, 64'd1);
      mem_model[a] = exp_w;
      cfg_wdis = wdis;
    end
    @(negedge clk);
    check("R6 ready back", {63'b0, req_ready}, 64'd1);
    check("R2 single write", {63'b0, mem_wr_req}, 64'd0);
    check("R8 invalid cleared", {63'b0, cfg_invalid}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) mem_model[i] = {$urandom, $urandom};
    rst_n = 1'b0; cfg_wdis = 1'b0; cfg_coalesce = 1'b0; req_valid = 1'b0;
    req_addr = '0; req_data = '0; req_be = '0; mem_rd_ack = 1'b0; mem_rd_data = '0;
    repeat (3) @(negedge clk);
    check("R1 ready held in reset", {63'b0, req_ready}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ready after reset", {63'b0, req_ready}, 64'd1);
    check("R1 no read", {63'b0, mem_rd_req}, 64'd0);
    check("R1 no write", {63'b0, mem_wr_req}, 64'd0);
    check("R1 invalid low", {63'b0, cfg_invalid}, 64'd0);

    // directed corners
    do_write(4'h1, 64'h0123_4567_89AB_CDEF, 8'hFF, 1'b0, 1'b0, 0, 1'b0); // R2
    do_write(4'h2, 64'hFFFF_FFFF_FFFF_FFFF, 8'h01, 1'b0, 1'b0, 0, 1'b0); // R4 low lane
    do_write(4'h3, 64'hA5A5_A5A5_A5A5_A5A5, 8'h80, 1'b0, 1'b1, 3, 1'b0); // R4 top lane
    do_write(4'h4, 64'h1111_2222_3333_4444, 8'h00, 1'b0, 1'b0, 1, 1'b0); // R4 no lanes
    do_write(4'h5, 64'hDEAD_BEEF_CAFE_F00D, 8'h3C, 1'b1, 1'b0, 0, 1'b0); // R7
    do_write(4'h6, 64'h0F0F_0F0F_0F0F_0F0F, 8'h0F, 1'b1, 1'b1, 0, 1'b0); // R8
    do_write(4'h7, 64'h7777_8888_9999_AAAA, 8'hFF, 1'b1, 1'b1, 0, 1'b0); // R8 full
    do_write(4'h8, 64'h0102_0304_0506_0708, 8'h5A, 1'b0, 1'b0, 2, 1'b1); // R9

    // constrained random
    for (int t = 0; t < 60; t++) begin
      logic [7:0] be;
      case ($urandom % 4)
        0:       be = 8'hFF;
        1:       be = 8'h01 << ($urandom % 8);
        default: be = 8'($urandom);
      endcase
      do_write(4'($urandom), {$urandom, $urandom}, be,
               ($urandom % 4) == 0, 1'($urandom), int'($urandom % 4), ($urandom % 8) == 0);
    end
    report();
  end
endmodule